// File: doc/BRIEF.md
# Phase-Ordered Jitter Histogram Accumulator

This block builds an on-chip probability profile of a jittery clock that is sampled by a second clock with a rational frequency ratio. Each cycle of `clk_i`, which is the reference clock, brings one sample bit of the jittery clock. A frame holds `KD` consecutive samples. Because the two frequencies relate as `KM/KD` with `KM` and `KD` coprime, the arrival index `i` of a sample within a frame maps to a unique phase slot `(i*KM) mod KD`. The block adds each sample into the counter for its phase slot. It does this over `NF` frames, so the counter array, read in slot order, rebuilds one period of the jittery clock.

A counter divided by `NF` estimates the probability that the jittery clock is high at that phase. Around an edge, the run of slot probabilities traces the cumulative distribution of the edge position. Slots that are neither 0 nor `NF` mark where jitter is present. Software or a monitor starts a run with `clear_i`, waits for `done_o` and then reads the counters through the combinational read port. The phase slot is advanced with an add and a conditional subtract, so no multiplier or divider is needed.

Top module: `jitter_hist_acc`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0 and every counter reads 0.
- R2: With `frame_start_i` high, the sample in that cycle has arrival index 0. The sample with arrival index `i` is counted at read address `(i*KM) mod KD`. For the test setting `KD`=7, `KM`=5, index 1 lands at address 5.
- R3: An accepted sample of 1 raises its counter by exactly one. A sample of 0 leaves the counter unchanged. With all-ones input over `NF` frames, every counter reads `NF`.
- R4: A counter at its maximum value `2**CW-1` stays there and does not wrap.
- R5: A `clear_i` pulse makes `busy_o` high from the next cycle for exactly `KD` cycles, while the counters are zeroed in address order. `clear_i` overrides every state and restarts the sweep at any time.
- R6: Samples are ignored before a clear, during the clear sweep, and after the sweep until the first cycle with `frame_start_i` high.
- R7: Once the first frame has started, frames follow back to back every `KD` cycles without further strobes. `done_o` rises in the cycle after the last sample of frame `NF` and stays high until `clear_i`.
- R8: While `done_o` is high, samples and frame strobes change no counter.
- R9: A `frame_start_i` pulse in the middle of a frame restarts the arrival index at 0. Counts already made stay.
- R10: `rd_data_o` follows `rd_addr_i` in the same cycle. An address of `KD` or above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Start a new run: zero counters, then wait for a frame strobe |
| frame_start_i | input | 1 | Marks the current sample as arrival index 0 |
| sample_i | input | 1 | Sampled level of the jittery clock |
| rd_addr_i | input | AW | Phase slot to read |
| busy_o | output | 1 | Clear sweep in progress |
| done_o | output | 1 | NF frames accumulated; counters frozen |
| rd_data_o | output | CW | Counter of the addressed phase slot |

## Verification
The bench drives patterns that separate reordering from arrival order. A single 1 at arrival index 1 must build up only at slot 5. A design that stored samples by arrival order, or stepped the phase by `KM` without reducing it, would fill the wrong slot. Frames after the first carry no strobe, so a controller that waits for a strobe per frame would never raise `done_o`, and one off by a frame would raise it a cycle or a frame early. Strobing every cycle with ones drives slot 0 past `NF` up to the counter maximum, where a wrapping counter would fall back to 0. Samples given while idle, while clearing, while armed without a strobe and while done must all leave the profile untouched. A clear restarted mid-sweep must still zero every slot.

// File: rtl/jha_pkg.sv
package jha_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_ARMED,
    ST_RUN,
    ST_DONE
  } jha_state_e;
endpackage

// File: rtl/jha_phase_gen.sv
module jha_phase_gen #(
  parameter int unsigned KD = 217,
  parameter int unsigned KM = 360,
  parameter int unsigned AW = $clog2(KD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          advance_i,
  output logic [AW-1:0] pos_o,
  output logic          last_o
);
  localparam logic [AW:0] STEP = (AW+1)'(KM % KD);
  localparam logic [AW:0] KDX  = (AW+1)'(KD);

  logic [AW-1:0] phase_q, idx_q, cur_idx;
  logic [AW:0]   sum, nxt;

  assign pos_o   = restart_i ? '0 : phase_q;
  assign cur_idx = restart_i ? '0 : idx_q;
  assign last_o  = (cur_idx == AW'(KD - 1));
  assign sum     = {1'b0, pos_o} + STEP;
  assign nxt     = (sum >= KDX) ? (sum - KDX) : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else if (advance_i) begin
      phase_q <= nxt[AW-1:0];
      idx_q   <= last_o ? '0 : cur_idx + 1'b1;
    end
  end

  // KD steps of KM mod KD return to phase 0: checks the incremental modulo
  a_r2_frame_wraps_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && last_o) |=> (phase_q == '0));
  a_r2_pos_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |-> (32'(pos_o) < KD));
endmodule

// File: rtl/jha_ctrl.sv
module jha_ctrl
  import jha_pkg::*;
#(
  parameter int unsigned KD = 217,
  parameter int unsigned NF = 1000,
  parameter int unsigned AW = $clog2(KD)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          frame_start_i,
  input  logic          frame_last_i,
  output logic          acc_we_o,
  output logic          clr_we_o,
  output logic [AW-1:0] clr_addr_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned FW = $clog2(NF + 1);

  jha_state_e    state_q;
  logic [AW-1:0] clr_q;
  logic [FW-1:0] frm_q;

  assign acc_we_o   = !clear_i && ((state_q == ST_RUN) || (state_q == ST_ARMED && frame_start_i));
  assign clr_we_o   = !clear_i && (state_q == ST_CLEAR);
  assign clr_addr_o = clr_q;
  assign busy_o     = (state_q == ST_CLEAR);
  assign done_o     = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      clr_q   <= '0;
      frm_q   <= '0;
    end else if (clear_i) begin
      state_q <= ST_CLEAR;
      clr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_CLEAR: begin
          if (clr_q == AW'(KD - 1)) begin
            state_q <= ST_ARMED;
            frm_q   <= '0;
          end else begin
            clr_q <= clr_q + 1'b1;
          end
        end
        ST_ARMED, ST_RUN: begin
          if (acc_we_o) begin
            state_q <= ST_RUN;
            if (frame_last_i) begin
              frm_q <= frm_q + 1'b1;
              if (frm_q == FW'(NF - 1)) state_q <= ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r5_sweep_ends_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && clr_q == AW'(KD - 1) && !clear_i) |=> (state_q == ST_ARMED));
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o);
  a_r7_frames_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(frm_q) <= NF));
  a_r8_no_acc_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) && done_o |-> $stable(frm_q));
endmodule

// File: rtl/jha_cnt_mem.sv
module jha_cnt_mem #(
  parameter int unsigned KD = 217,
  parameter int unsigned AW = $clog2(KD),
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_we_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_bit_i,
  input  logic          clr_we_i,
  input  logic [AW-1:0] clr_addr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [CW-1:0] rd_data_o
);
  localparam logic [CW-1:0] MAXC = '1;

  logic [CW-1:0] cnt_q [KD];
  logic [CW-1:0] cur_cnt, inc_cnt;

  assign cur_cnt   = cnt_q[acc_addr_i];
  assign inc_cnt   = (cur_cnt == MAXC) ? cur_cnt : cur_cnt + 1'b1;
  assign rd_data_o = (32'(rd_addr_i) < KD) ? cnt_q[rd_addr_i] : '0;

  for (genvar g = 0; g < KD; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          cnt_q[g] <= '0;
      else if (clr_we_i && clr_addr_i == AW'(g))            cnt_q[g] <= '0;
      else if (acc_we_i && acc_bit_i && acc_addr_i == AW'(g)) cnt_q[g] <= inc_cnt;
    end
  end

  a_r4_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && acc_bit_i && cur_cnt == MAXC) |=> (cnt_q[$past(acc_addr_i)] == MAXC));
  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && acc_bit_i && cur_cnt != MAXC && !clr_we_i)
      |=> (cnt_q[$past(acc_addr_i)] == $past(cur_cnt) + 1'b1));
endmodule

// File: rtl/jitter_hist_acc.sv
module jitter_hist_acc #(
  parameter int unsigned KD = 217,
  parameter int unsigned KM = 360,
  parameter int unsigned NF = 1000,
  parameter int unsigned AW = $clog2(KD),
  parameter int unsigned CW = $clog2(NF + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          frame_start_i,
  input  logic          sample_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] rd_data_o
);
  logic          acc_we, clr_we, frame_last;
  logic [AW-1:0] pos, clr_addr;

  jha_phase_gen #(.KD(KD), .KM(KM), .AW(AW)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (frame_start_i),
    .advance_i (acc_we),
    .pos_o     (pos),
    .last_o    (frame_last)
  );

  jha_ctrl #(.KD(KD), .NF(NF), .AW(AW)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear_i),
    .frame_start_i (frame_start_i),
    .frame_last_i  (frame_last),
    .acc_we_o      (acc_we),
    .clr_we_o      (clr_we),
    .clr_addr_o    (clr_addr),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  jha_cnt_mem #(.KD(KD), .AW(AW), .CW(CW)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_we_i   (acc_we),
    .acc_addr_i (pos),
    .acc_bit_i  (sample_i),
    .clr_we_i   (clr_we),
    .clr_addr_i (clr_addr),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o)
  );

  a_r6_no_acc_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !acc_we);
  a_r5_busy_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: tb/jitter_hist_acc_test.sv
`timescale 1ns/1ps
module jitter_hist_acc_test;
  localparam int KD = 7;
  localparam int KM = 5;
  localparam int NF = 4;
  localparam int AW = 3;
  localparam int CW = 3;
  localparam int MAXC = 7;

  logic clk = 0, rst_n = 0, clear = 0, fs = 0, smp = 0;
  logic [AW-1:0] rd_addr = '0;
  logic busy, done;
  logic [CW-1:0] rd_data;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  jitter_hist_acc #(.KD(KD), .KM(KM), .NF(NF), .AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .frame_start_i(fs),
    .sample_i(smp), .rd_addr_i(rd_addr), .busy_o(busy), .done_o(done),
    .rd_data_o(rd_data));

  // behavioural reference: 0 idle, 1 clearing, 2 armed, 3 run, 4 done
  int ms, mclr, mi, mfrm;
  int mcnt [KD];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mclr = 0; mi = 0; mfrm = 0;
      foreach (mcnt[k]) mcnt[k] = 0;
    end else if (clear) begin
      ms = 1; mclr = 0;
    end else begin
      case (ms)
        1: begin
          mcnt[mclr] = 0;
          if (mclr == KD - 1) begin ms = 2; mfrm = 0; end
          else mclr++;
        end
        2, 3: if (ms == 3 || fs) begin
          int ii, jj;
          ii = fs ? 0 : mi;
          jj = (ii * KM) % KD;
          if (smp && mcnt[jj] < MAXC) mcnt[jj]++;
          if (ii == KD - 1) begin
            mi = 0; mfrm++;
            ms = (mfrm == NF) ? 4 : 3;
          end else begin
            mi = ii + 1; ms = 3;
          end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got %0d exp %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, mid-cycle
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R5 busy", busy, ms == 1);
      chk("R7 done", done, ms == 4);
      chk("R2 rd_data", rd_data, (rd_addr < KD) ? mcnt[rd_addr] : 0);
    end
  end

  task automatic rd(string tag, int addr, int exp);
    rd_addr = AW'(addr);
    #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic bit pat(int kind, int f, int i);
    case (kind)
      0: return 1'b1;
      1: return i == 1;
      2: return 1'($urandom_range(0, 1));
      default: return 1'((i + f) % 2);
    endcase
  endfunction

  task automatic frames(int kind, int nf, bit fs_each);
    for (int f = 0; f < nf; f++)
      for (int i = 0; i < KD; i++) begin
        @(negedge clk);
        fs = (i == 0) && (fs_each || f == 0);
        smp = pat(kind, f, i);
        rd_addr = rd_addr + 1'b1;
      end
    @(negedge clk);
    fs = 0; smp = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    chk("R5 busy after clear", busy, 1);
    repeat (KD - 1) @(negedge clk);
    chk("R5 busy last sweep cycle", busy, 1);
    @(negedge clk);
    chk("R5 busy end", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    for (int a = 0; a < KD; a++) rd("R1 counter zero", a, 0);

    // R6: idle and armed samples ignored
    for (int k = 0; k < 5; k++) begin @(negedge clk); smp = 1; end
    do_clear();
    smp = 1;
    repeat (4) @(negedge clk);
    smp = 0;
    @(negedge clk);
    for (int a = 0; a < KD; a++) rd("R6 armed ignore", a, 0);

    // R2: single 1 at arrival index 1 -> slot 5
    frames(1, NF, 1'b1);
    chk("R7 done after NF frames", done, 1);
    rd("R2 slot 5", 5, NF);
    rd("R2 slot 0", 0, 0);
    rd("R2 slot 1", 1, 0);

    // R8: input while done ignored
    for (int k = 0; k < 8; k++) begin @(negedge clk); fs = 1; smp = 1; end
    @(negedge clk); fs = 0; smp = 0;
    rd("R8 slot 0 frozen", 0, 0);
    rd("R8 slot 5 frozen", 5, NF);
    chk("R7 done held", done, 1);

    // R3: all ones
    do_clear();
    chk("R5 done cleared", done, 0);
    frames(0, NF, 1'b1);
    for (int a = 0; a < KD; a++) rd("R3 all ones", a, NF);
    rd("R10 out of range", 7, 0);

    // R7: strobe only on first frame, random data (model checks each cycle)
    do_clear();
    frames(2, NF, 1'b0);
    chk("R7 done without strobes", done, 1);

    // R7: done not early
    do_clear();
    frames(3, NF - 1, 1'b1);
    chk("R7 not done before last frame", done, 0);
    frames(3, 1, 1'b1);
    chk("R7 done after last frame", done, 1);

    // R4 / R9: strobe every cycle pins index 0 -> slot 0 saturates
    do_clear();
    for (int k = 0; k < 12; k++) begin @(negedge clk); fs = 1; smp = 1; end
    @(negedge clk); fs = 0; smp = 0;
    rd("R4 saturated", 0, MAXC);
    rd("R9 slot 5 untouched", 5, 0);
    chk("R9 no done", done, 0);

    // R5: clear restarted mid-sweep still zeroes all
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    repeat (3) @(negedge clk);
    do_clear();
    for (int a = 0; a < KD; a++) rd("R5 restarted clear", a, 0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule